// File: doc/BRIEF.md
# Timestamp Delta Classifying Encoder

This block compresses a stream of timestamps for a later byte packer. Each cycle a producer may present one timestamp with a valid strobe. For each accepted sample, the block emits one registered word one clock later. The first sample after reset is sent as its absolute value. Every later sample is sent as the wrapped difference from the last accepted timestamp.

Each result carries a 2-bit size code. The code tells the receiver how many low bytes of the value are significant: one byte, two bytes, or the full word. A downstream stage can then drop the leading zero bytes. The block has no backpressure. The receiver must take each result in the cycle it appears.

Top module: `ts_delta_enc`

## Requirements
- R1: When no sample has been accepted since reset, the next accepted sample produces size code 2'b10 and its full timestamp as the value.
- R2: After that, the value is the current timestamp minus the stored timestamp, modulo 2^32. A timestamp that wraps past zero gives a small positive difference.
- R3: The size code is 2'b00 for a difference of 0 to 0xFF, 2'b01 for 0x100 to 0xFFFF, and 2'b10 for 0x10000 or more. The code 2'b11 never appears.
- R4: The value is the difference itself, zero-extended to 32 bits, whatever the size code.
- R5: A sample accepted at clock edge N is presented with the output strobe high during the cycle that follows edge N. A cycle without a valid input gives no output strobe at the next edge.
- R6: Cycles with the valid strobe low change neither the stored timestamp nor the seen-a-sample flag. The next sample is differenced against the last accepted one, however long the gap.
- R7: A cycle with reset high ignores its input, even when valid is high. It clears the flag and the stored timestamp, and it clears all outputs to zero at that edge.
- R8: A result that was on the outputs when reset was sampled is removed at that edge and is not shown again.
- R9: While the output strobe is low, the size code and the value are zero.
- R10: Every accepted sample, including the first one after reset, becomes the stored timestamp for the next difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_time | input | 32 | Sample timestamp |
| enc_valid | output | 1 | Result strobe |
| enc_size | output | 2 | Significant-byte code: 00 one byte, 01 two bytes, 10 full word |
| enc_value | output | 32 | Absolute timestamp or zero-extended difference |

## Verification
Every result is due exactly one edge after its sample is taken. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It then compares all three outputs at the next falling edge, so each cycle's comparison covers exactly the sample from the previous cycle. A reset cycle is expected to show zeros right after its edge. The sample that follows reset is expected to show the absolute value, not a difference from the sample taken before the reset.

// File: rtl/ts_delta_enc.sv
module ts_delta_enc #(
  parameter int TS_W  = 32,
  parameter int SML_W = 8,
  parameter int MID_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_valid,
  input  logic [TS_W-1:0] smp_time,
  output logic            enc_valid,
  output logic [1:0]      enc_size,
  output logic [TS_W-1:0] enc_value
);

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_FULL = 2'b10;

  logic            seen_q;
  logic [TS_W-1:0] last_q;
  logic [TS_W-1:0] diff;
  logic [1:0]      size_d;

  assign diff = smp_time - last_q;

  always_comb begin
    if (!seen_q)                         size_d = SZ_FULL;
    else if (diff[TS_W-1:SML_W] == '0)   size_d = SZ_BYTE;
    else if (diff[TS_W-1:MID_W] == '0)   size_d = SZ_HALF;
    else                                 size_d = SZ_FULL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= 1'b0;
      last_q    <= '0;
      enc_valid <= 1'b0;
      enc_size  <= '0;
      enc_value <= '0;
    end else if (smp_valid) begin
      seen_q    <= 1'b1;
      last_q    <= smp_time;
      enc_valid <= 1'b1;
      enc_size  <= size_d;
      enc_value <= seen_q ? diff : smp_time;
    end else begin
      enc_valid <= 1'b0;
      enc_size  <= '0;
      enc_value <= '0;
    end
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> enc_valid);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !enc_valid);
  p_quiet_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !enc_valid |-> (enc_size == 2'b00 && enc_value == '0));
  p_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
    enc_size != 2'b11);
  p_byte_fits_r3: assert property (@(posedge clk) disable iff (rst)
    (enc_valid && enc_size == SZ_BYTE) |-> enc_value[TS_W-1:SML_W] == '0);
  p_half_fits_r4: assert property (@(posedge clk) disable iff (rst)
    (enc_valid && enc_size == SZ_HALF) |-> enc_value[TS_W-1:MID_W] == '0);
  p_gap_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && seen_q) |=> ($stable(last_q) && seen_q));
  p_store_r10: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> (seen_q && last_q == $past(smp_time)));

endmodule

// File: tb/ts_delta_enc_tb_top.sv
module ts_delta_enc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_time = '0;
  logic        enc_valid;
  logic [1:0]  enc_size;
  logic [31:0] enc_value;

  int checks = 0;
  int errors = 0;

  bit          m_seen;
  logic [31:0] m_last;
  bit          e_valid;
  logic [1:0]  e_size;
  logic [31:0] e_value;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_delta_enc dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_time(smp_time),
    .enc_valid(enc_valid), .enc_size(enc_size), .enc_value(enc_value)
  );

  function automatic logic [1:0] band(input longint unsigned d);
    if (d < 256)        return 2'b00;
    else if (d < 65536) return 2'b01;
    return 2'b10;
  endfunction

  task automatic step(input bit r, input bit v, input logic [31:0] ts, input string req);
    longint unsigned d;
    rst = r; smp_valid = v; smp_time = ts;
    @(posedge clk);
    if (r) begin
      m_seen = 0; m_last = '0; e_valid = 0; e_size = 2'b00; e_value = '0;
    end else if (v) begin
      e_valid = 1;
      if (!m_seen) begin
        e_size = 2'b10; e_value = ts;
      end else begin
        d = (longint'(ts) + 64'h1_0000_0000 - longint'(m_last)) % 64'h1_0000_0000;
        e_size = band(d); e_value = d[31:0];
      end
      m_seen = 1; m_last = ts;
    end else begin
      e_valid = 0; e_size = 2'b00; e_value = '0;
    end
    @(negedge clk);
    checks++;
    if (enc_valid !== e_valid || enc_size !== e_size || enc_value !== e_value) begin
      errors++;
      $display("FAIL %s: got v=%0b sz=%b val=%h expected v=%0b sz=%b val=%h",
               req, enc_valid, enc_size, enc_value, e_valid, e_size, e_value);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] t;
    @(negedge clk);
    step(1, 0, 32'h0, "R7 reset state");
    step(1, 1, 32'h1234_5678, "R7 input ignored in reset");
    step(0, 0, 32'h0, "R9 idle after reset");
    step(0, 1, 32'h0000_1000, "R1 first sample absolute");
    step(0, 1, 32'h0000_1000, "R3 zero delta");
    step(0, 1, 32'h0000_10FF, "R3 delta 255");
    step(0, 1, 32'h0000_11FF, "R3 delta 256");
    step(0, 1, 32'h0001_11FE, "R3 delta 65535");
    step(0, 1, 32'h0002_11FE, "R4 delta 65536");
    step(0, 0, 32'hDEAD_BEEF, "R9 gap outputs zero");
    step(0, 0, 32'h0, "R5 no strobe in gap");
    step(0, 1, 32'h0002_1210, "R6 delta across gap");
    step(0, 1, 32'hFFFF_FFF0, "R4 large delta");
    step(0, 1, 32'h0000_0010, "R2 wraparound delta");
    step(0, 1, 32'h0003_0000, "R8 result before reset");
    step(1, 1, 32'h0003_0005, "R8 result discarded");
    step(0, 0, 32'h0, "R8 nothing after reset");
    step(0, 1, 32'hABCD_0000, "R1 absolute after mid reset");
    step(0, 1, 32'hABCD_0000, "R10 first sample stored");
    step(0, 1, 32'hABCD_0005, "R3 small");
    step(0, 1, 32'hABCD_0125, "R3 medium");
    step(0, 1, 32'hABCE_0125, "R3 full 65536");
    t = 32'hABCE_0125;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      case ($urandom % 4)
        0: d = $urandom % 256;
        1: d = 256 + $urandom % 65280;
        2: d = $urandom;
        default: d = 0;
      endcase
      if ($urandom % 5 == 0) step(0, 0, $urandom, "R6 random gap");
      t = t + d;
      step(0, 1, t, "R2 random delta");
    end
    step(0, 0, 32'h0, "R9 final idle");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule